// File: doc/BRIEF.md
# Disk Controller Register File

This block holds the processor-visible registers of a small disk controller. It sits on a 16-bit I/O bus and matches the low 12 address bits against five word slots at a base offset. The slots are a control/status word, a transfer (memory) address, a disk address, a multipurpose word and a transfer-address extension. Each slot has its own write mask and reset value. The control/status word combines the live drive inputs with stored command fields and a sequencer-written error code.

A command starts when software writes the control/status word with its controller-ready bit at 0. This is an active-low GO. The block then drops `ctrlReady` and gives the command sequencer a one-cycle `goPulse`, with the function code and drive select on dedicated outputs. When the sequencer reports completion, the ready bit returns, the error code is captured, and an interrupt request is raised if interrupts are enabled. While the controller is busy, every bus access to the register slots is refused.

Top module: `dskRegFile`

## Requirements
- R1: The slots are decoded at base 12'h100. Control/status is at +0, transfer address at +2, disk address at +4, multipurpose at +6 and extension at +8. Any other address, including odd ones, gives no acknowledge, no refusal and no read data.
- R2: In the control/status word, only bits 9:1 accept writes. Writes to bits 0 and 15:10 have no effect.
- R3: After reset, control/status reads 16'h0080 when the drive inputs are low. The transfer address, disk address, multipurpose and extension slots read 0, `ctrlReady` is 1, and `irqReq` and `goPulse` are 0.
- R4: Control/status bit 0 follows `driveReady` and bit 14 follows `driveError`.
- R5: Control/status bit 15 is 1 exactly when the error field (bits 13:10) is non-zero or bit 14 is 1.
- R6: An accepted control/status write with bit 7 at 0 does three things on the next cycle. It drops `ctrlReady`, pulses `goPulse` for one cycle and clears the error field. `funcCode` shows bits 3:1 and `driveSel` shows bits 9:8. A `cmdDone` while busy sets `ctrlReady` again and loads `cmdErr` into bits 13:10. Error code values are 1 incomplete, 2 data check, 3 header check, 4 data late, 5 header not found, 8 no memory and 9 memory parity.
- R7: Transfer-address bit 0 always reads 0. `xferAddr` is {control/status bits 5:4, transfer address}. The disk address holds all 16 bits. The extension keeps bits 5:0 and reads 0 above them.
- R8: While `ctrlReady` is 0, a read or write to a decoded slot yields `busRefused` on the next cycle, with no read data and no state change.
- R9: When `ctrlReady` rises through `cmdDone` while interrupt enable (control/status bit 6) is 1, `irqReq` rises in the same cycle. With interrupt enable at 0, it stays low.
- R10: A pending `irqReq` clears one cycle after `irqAck`, or after an accepted control/status write with bit 6 at 0.
- R11: An accepted read gives `busRdata` with `busRdValid` and `busAck` one cycle after the request.
- R12: A `mpLoad` pulse stores `mpData` into the multipurpose slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Low I/O address bits |
| busRead | input | 1 | Read request |
| busWrite | input | 1 | Write request |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data |
| busRdValid | output | 1 | Read data valid |
| busAck | output | 1 | Access accepted |
| busRefused | output | 1 | Access refused, controller busy |
| driveReady | input | 1 | Selected drive ready |
| driveError | input | 1 | Selected drive error |
| cmdDone | input | 1 | Command finished, from sequencer |
| cmdErr | input | 4 | Error code at completion |
| mpLoad | input | 1 | Load multipurpose word |
| mpData | input | 16 | Value for multipurpose word |
| irqAck | input | 1 | Interrupt acknowledge |
| irqReq | output | 1 | Interrupt request |
| ctrlReady | output | 1 | Controller ready (GO bit) |
| goPulse | output | 1 | One-cycle command launch |
| funcCode | output | 3 | Function code to run |
| driveSel | output | 2 | Selected drive |
| xferAddr | output | 18 | Full transfer address |
| diskAddr | output | 16 | Disk address word |

## Verification
Every register output settles one clock edge after its cause. Read data, `busAck`, `busRefused`, `goPulse`, the ready bit and `irqReq` are all due at the first edge after the request, `cmdDone` or `irqAck` was presented. The bench drives inputs on the falling edge and samples on the next falling edge, so each check sees exactly that one register stage. Expected read words go into a queue when a read is issued. A monitor takes one entry off the queue for each `busRdValid` and reports any read data that arrives with no request waiting for it.

// File: rtl/dsk_reg_pkg.sv
package dsk_reg_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int ERR_W  = 4;
  localparam int EXT_W  = 6;
  localparam logic [ADDR_W-1:0] BASE_ADDR = 12'h100;

  typedef enum logic [2:0] {
    SEL_CS   = 3'd0,
    SEL_BA   = 3'd1,
    SEL_DA   = 3'd2,
    SEL_MP   = 3'd3,
    SEL_EXT  = 3'd4,
    SEL_NONE = 3'd7
  } regSelE;

  typedef struct packed {
    logic   wrCs;
    logic   wrBa;
    logic   wrDa;
    logic   wrMp;
    logic   wrExt;
    logic   rdEn;
    regSelE rdSel;
  } regStrobeS;
endpackage

// File: rtl/dskRegCtrl.sv
module dskRegCtrl
  import dsk_reg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] BASE = BASE_ADDR,
  parameter int NUM_REGS = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busRead,
  input  logic          busWrite,
  input  logic          ctrlReady,
  output regStrobeS     strobes,
  output logic          busAck,
  output logic          busRefused,
  output logic          busRdValid
);
  localparam logic [AW-1:0] SPAN = AW'(2 * NUM_REGS);

  logic [AW-1:0] offset;
  logic          inRange;
  logic          hit;
  logic          req;
  logic          accept;
  logic          refuse;
  regSelE        sel;

  assign offset  = busAddr - BASE;
  assign inRange = (busAddr >= BASE) && (offset < SPAN) && !offset[0];
  assign req     = busRead || busWrite;

  always_comb begin
    sel = SEL_NONE;
    if (inRange) begin
      case (offset[3:1])
        3'd0:    sel = SEL_CS;
        3'd1:    sel = SEL_BA;
        3'd2:    sel = SEL_DA;
        3'd3:    sel = SEL_MP;
        3'd4:    sel = SEL_EXT;
        default: sel = SEL_NONE;
      endcase
    end
  end

  assign hit    = (sel != SEL_NONE);
  assign accept = hit && req && ctrlReady;
  assign refuse = hit && req && !ctrlReady;

  always_comb begin
    strobes       = '0;
    strobes.rdSel = sel;
    if (accept) begin
      strobes.rdEn  = busRead;
      strobes.wrCs  = busWrite && (sel == SEL_CS);
      strobes.wrBa  = busWrite && (sel == SEL_BA);
      strobes.wrDa  = busWrite && (sel == SEL_DA);
      strobes.wrMp  = busWrite && (sel == SEL_MP);
      strobes.wrExt = busWrite && (sel == SEL_EXT);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busAck     <= 1'b0;
      busRefused <= 1'b0;
      busRdValid <= 1'b0;
    end else begin
      busAck     <= accept;
      busRefused <= refuse;
      busRdValid <= accept && busRead;
    end
  end
endmodule

// File: rtl/dskRegData.sv
module dskRegData
  import dsk_reg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int EW = ERR_W,
  parameter int XW = EXT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  regStrobeS     strobes,
  input  logic [DW-1:0] busWdata,
  input  logic          driveReady,
  input  logic          driveError,
  input  logic          cmdDone,
  input  logic [EW-1:0] cmdErr,
  input  logic          mpLoad,
  input  logic [DW-1:0] mpData,
  input  logic          irqAck,
  output logic [DW-1:0] busRdata,
  output logic          ctrlReady,
  output logic          goPulse,
  output logic [2:0]    funcCode,
  output logic [1:0]    driveSel,
  output logic          irqReq,
  output logic [DW+1:0] xferAddr,
  output logic [DW-1:0] diskAddr
);
  logic [2:0]    func;
  logic [1:0]    baHi;
  logic          intEn;
  logic          crdy;
  logic [1:0]    dsel;
  logic [EW-1:0] errCode;
  logic [DW-1:1] baReg;
  logic [DW-1:0] daReg;
  logic [DW-1:0] mpReg;
  logic [XW-1:0] extReg;
  logic [DW-1:0] csView;
  logic [DW-1:0] rdMux;
  logic          launch;
  logic          finish;
  logic          unusedWd;

  assign unusedWd = ^{busWdata[0], busWdata[DW-1:10]};
  assign launch   = strobes.wrCs && !busWdata[7];
  assign finish   = cmdDone && !crdy;

  always_comb begin
    csView        = '0;
    csView[0]     = driveReady;
    csView[3:1]   = func;
    csView[5:4]   = baHi;
    csView[6]     = intEn;
    csView[7]     = crdy;
    csView[9:8]   = dsel;
    csView[13:10] = errCode;
    csView[14]    = driveError;
    csView[15]    = (|errCode) || driveError;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      func    <= '0;
      baHi    <= '0;
      intEn   <= 1'b0;
      crdy    <= 1'b1;
      dsel    <= '0;
      errCode <= '0;
      goPulse <= 1'b0;
    end else begin
      goPulse <= launch;
      if (strobes.wrCs) begin
        func  <= busWdata[3:1];
        baHi  <= busWdata[5:4];
        intEn <= busWdata[6];
        dsel  <= busWdata[9:8];
      end
      if (launch) begin
        crdy    <= 1'b0;
        errCode <= '0;
      end else if (finish) begin
        crdy    <= 1'b1;
        errCode <= cmdErr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq <= 1'b0;
    end else if (irqAck || (strobes.wrCs && !busWdata[6])) begin
      irqReq <= 1'b0;
    end else if (finish && intEn) begin
      irqReq <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baReg  <= '0;
      daReg  <= '0;
      mpReg  <= '0;
      extReg <= '0;
    end else begin
      if (strobes.wrBa)  baReg  <= busWdata[DW-1:1];
      if (strobes.wrDa)  daReg  <= busWdata;
      if (mpLoad)        mpReg  <= mpData;
      else if (strobes.wrMp) mpReg <= busWdata;
      if (strobes.wrExt) extReg <= busWdata[XW-1:0];
    end
  end

  always_comb begin
    case (strobes.rdSel)
      SEL_CS:  rdMux = csView;
      SEL_BA:  rdMux = {baReg, 1'b0};
      SEL_DA:  rdMux = daReg;
      SEL_MP:  rdMux = mpReg;
      SEL_EXT: rdMux = {{(DW-XW){1'b0}}, extReg};
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              busRdata <= '0;
    else if (strobes.rdEn)  busRdata <= rdMux;
  end

  assign ctrlReady = crdy;
  assign funcCode  = func;
  assign driveSel  = dsel;
  assign xferAddr  = {baHi, baReg, 1'b0};
  assign diskAddr  = daReg;
endmodule

// File: rtl/dskRegFile.sv
module dskRegFile
  import dsk_reg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [11:0] busAddr,
  input  logic        busRead,
  input  logic        busWrite,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  output logic        busRdValid,
  output logic        busAck,
  output logic        busRefused,
  input  logic        driveReady,
  input  logic        driveError,
  input  logic        cmdDone,
  input  logic [3:0]  cmdErr,
  input  logic        mpLoad,
  input  logic [15:0] mpData,
  input  logic        irqAck,
  output logic        irqReq,
  output logic        ctrlReady,
  output logic        goPulse,
  output logic [2:0]  funcCode,
  output logic [1:0]  driveSel,
  output logic [17:0] xferAddr,
  output logic [15:0] diskAddr
);
  regStrobeS strobes;

  dskRegCtrl #(.AW(ADDR_W), .BASE(BASE_ADDR), .NUM_REGS(5)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .ctrlReady(ctrlReady), .strobes(strobes),
    .busAck(busAck), .busRefused(busRefused), .busRdValid(busRdValid)
  );

  dskRegData #(.DW(DATA_W), .EW(ERR_W), .XW(EXT_W)) i_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata),
    .driveReady(driveReady), .driveError(driveError), .cmdDone(cmdDone),
    .cmdErr(cmdErr), .mpLoad(mpLoad), .mpData(mpData), .irqAck(irqAck),
    .busRdata(busRdata), .ctrlReady(ctrlReady), .goPulse(goPulse),
    .funcCode(funcCode), .driveSel(driveSel), .irqReq(irqReq),
    .xferAddr(xferAddr), .diskAddr(diskAddr)
  );
endmodule

// File: rtl/dskRegFileChk.sv
module dskRegFileChk (
  input logic clk,
  input logic rstN,
  input logic busAck,
  input logic busRefused,
  input logic busRdValid,
  input logic cmdDone,
  input logic irqReq,
  input logic ctrlReady,
  input logic goPulse
);
  // R6
  go_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    goPulse |-> !ctrlReady);
  // R6
  go_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    goPulse |=> !goPulse);
  // R6
  ready_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlReady) |-> $past(cmdDone));
  // R8
  ack_refuse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busAck && busRefused));
  // R8
  refuse_when_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRefused |-> $past(!ctrlReady));
  // R11
  rdvalid_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdValid |-> busAck);
  // R9
  irq_on_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $rose(ctrlReady));
endmodule

bind dskRegFile dskRegFileChk i_chk (
  .clk(clk), .rstN(rstN), .busAck(busAck), .busRefused(busRefused),
  .busRdValid(busRdValid), .cmdDone(cmdDone), .irqReq(irqReq),
  .ctrlReady(ctrlReady), .goPulse(goPulse)
);

// File: tb/test_dskRegFile.sv
module test_dskRegFile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busRead = 1'b0, busWrite = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        busRdValid, busAck, busRefused;
  logic        driveReady = 1'b0, driveError = 1'b0;
  logic        cmdDone = 1'b0;
  logic [3:0]  cmdErr = '0;
  logic        mpLoad = 1'b0;
  logic [15:0] mpData = '0;
  logic        irqAck = 1'b0;
  logic        irqReq, ctrlReady, goPulse;
  logic [2:0]  funcCode;
  logic [1:0]  driveSel;
  logic [17:0] xferAddr;
  logic [15:0] diskAddr;

  int nChecks = 0;
  int nFails  = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  dskRegFile i_dskRegFile (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: R11 read data arrives one cycle after request
  always @(negedge clk) begin
    if (rstN && busRdValid) begin
      if (expQ.size() == 0) check("R11 unexpected read data", 32'(busRdata), 32'hDEAD);
      else check(tagQ.pop_front(), 32'(busRdata), 32'(expQ.pop_front()));
    end
  end

  task automatic wrReg(logic [11:0] a, logic [15:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk); busWrite = 1'b0;
  endtask

  task automatic rdReg(logic [11:0] a, logic [15:0] exp, string tag);
    @(negedge clk); busAddr = a; busRead = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); busRead = 1'b0;
  endtask

  task automatic finishCmd(logic [3:0] e);
    @(negedge clk); cmdDone = 1'b1; cmdErr = e;
    @(negedge clk); cmdDone = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R3 ctrlReady", 32'(ctrlReady), 1);
    check("R3 irqReq", 32'(irqReq), 0);
    check("R3 goPulse", 32'(goPulse), 0);
    rdReg(12'h100, 16'h0080, "R3 cs reset");
    rdReg(12'h102, 16'h0000, "R3 ba reset");
    rdReg(12'h104, 16'h0000, "R3 da reset");
    rdReg(12'h106, 16'h0000, "R3 mp reset");
    rdReg(12'h108, 16'h0000, "R3 ext reset");

    driveReady = 1'b1;
    rdReg(12'h100, 16'h0081, "R4 drive ready bit");

    wrReg(12'h100, 16'hFCFE);
    rdReg(12'h100, 16'h00FF, "R2 cs write mask");
    check("R6 funcCode", 32'(funcCode), 7);
    wrReg(12'h100, 16'h0380);
    rdReg(12'h100, 16'h0381, "R2 drive select bits");
    check("R6 driveSel", 32'(driveSel), 3);

    wrReg(12'h102, 16'hFFFF);
    rdReg(12'h102, 16'hFFFE, "R7 ba bit0");
    wrReg(12'h100, 16'h00B0);
    check("R7 xferAddr", 32'(xferAddr), 32'h3FFFE);
    wrReg(12'h104, 16'hA5C3);
    rdReg(12'h104, 16'hA5C3, "R7 da full");
    check("R7 diskAddr", 32'(diskAddr), 32'hA5C3);
    wrReg(12'h106, 16'h1234);
    rdReg(12'h106, 16'h1234, "R1 mp slot");
    wrReg(12'h108, 16'hFFFF);
    rdReg(12'h108, 16'h003F, "R7 ext width");

    for (int k = 0; k < 2; k++) begin
      @(negedge clk); busAddr = (k == 0) ? 12'h10A : 12'h103; busRead = 1'b1;
      @(negedge clk); busRead = 1'b0;
      check("R1 unmapped ack", 32'({busAck, busRefused, busRdValid}), 0);
    end

    @(negedge clk); mpLoad = 1'b1; mpData = 16'hBEEF;
    @(negedge clk); mpLoad = 1'b0;
    rdReg(12'h106, 16'hBEEF, "R12 mp load");

    driveError = 1'b1;
    rdReg(12'h100, 16'hC0B1, "R5 drive error composite");
    driveError = 1'b0;

    wrReg(12'h100, 16'h004C);
    check("R6 goPulse", 32'(goPulse), 1);
    check("R6 busy", 32'(ctrlReady), 0);
    check("R6 funcCode go", 32'(funcCode), 6);
    @(negedge clk);
    check("R6 goPulse one cycle", 32'(goPulse), 0);

    @(negedge clk); busAddr = 12'h100; busRead = 1'b1;
    @(negedge clk); busRead = 1'b0;
    check("R8 read refused", 32'({busRefused, busRdValid}), 32'b10);
    wrReg(12'h102, 16'h1234);
    check("R8 write refused", 32'({busRefused, busAck}), 32'b10);

    finishCmd(4'd5);
    check("R6 ready back", 32'(ctrlReady), 1);
    check("R9 irq raised", 32'(irqReq), 1);
    rdReg(12'h100, 16'h94CD, "R5 error field composite");
    rdReg(12'h102, 16'hFFFE, "R8 ba unchanged");

    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
    check("R10 irq ack", 32'(irqReq), 0);

    wrReg(12'h100, 16'h0042);
    finishCmd(4'd0);
    rdReg(12'h100, 16'h00C3, "R6 error cleared on go");
    check("R9 irq second", 32'(irqReq), 1);
    wrReg(12'h100, 16'h0080);
    check("R10 irq cleared by ie", 32'(irqReq), 0);

    wrReg(12'h100, 16'h0004);
    finishCmd(4'd0);
    check("R9 no irq without ie", 32'(irqReq), 0);

    repeat (2) @(negedge clk);
    check("R11 queue drained", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule